// File: doc/BRIEF.md
# Vector register-group overlap legality checker

This block sits in a vector instruction decoder and judges one widening or narrowing arithmetic instruction per cycle. From the destination and the two source register numbers, the signed LMUL exponent and three form flags, it works out the register-group size and each source's effective group exponent. It then applies the alignment rule and the overlap window that fit the op class. The decoder reads back one illegal flag and a reason code that names the first rule broken.

The flags say whether the op is widening or narrowing, whether vs2 already carries the doubled element width, and whether the first source is a vector register rather than a scalar. A narrowing float conversion is presented with the vector-first-source flag low. The verdict is registered, so it appears one clock after the inputs are applied. Raising the trap, tracking vtype and executing the instruction are left to other blocks.

Top module: `vrg_overlap_checker`

## Requirements
- R1: The verdict for inputs applied at one rising clock edge appears on the outputs right after the next rising edge. While rst_n is low the outputs read illegal_o=0 and reason_o=0.
- R2: reason_o encodes 0 = legal, 1 = destination misaligned, 2 = source misaligned, 3 = vs2 overlap and 4 = vs1 overlap. illegal_o is 1 exactly when reason_o is not 0.
- R3: With G = 1 << max(0, lmul_exp + 1), a widening op (is_narrow_i=0) whose vd is not a multiple of G gives reason 1.
- R4: A narrowing op (is_narrow_i=1) whose vs2 is not a multiple of G gives reason 2. The alignment of vd is not checked for narrowing.
- R5: Widening with a source exponent below zero is illegal only when the checked source equals vd. A nearby but different register is legal.
- R6: Widening with a source exponent e >= 0 is illegal when src < vd + G - 2^e and vd < src + 2^e. A source that sits only on the upper part of the destination group is legal.
- R7: For widening, a vs2 that already has the doubled width (vs2_wide_i=1) is never checked for overlap.
- R8: vs1 is checked for overlap, with exponent lmul_exp, only when vs1_vec_i=1. This holds for both op classes. When vs1_vec_i=0, the value of vs1_i does not change the verdict.
- R9: For narrowing, a source is illegal when src < vd and vd <= src + G - 1, so vd equal to the source base is legal. vs2 is always checked.
- R10: When several rules fail at once, the code reports alignment first, then vs2 overlap, then vs1 overlap.
- R11: lmul_exp is 3-bit two's complement covering -3..+3. The bounds are computed wide enough that vd + G does not wrap at the top of the register file.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vd_i | input | 5 | Destination register number |
| vs1_i | input | 5 | First source register number |
| vs2_i | input | 5 | Second source register number |
| lmul_exp_i | input | 3 | Signed LMUL exponent |
| is_narrow_i | input | 1 | 1 = narrowing op, 0 = widening op |
| vs2_wide_i | input | 1 | vs2 already has the doubled element width |
| vs1_vec_i | input | 1 | First source is a vector register |
| illegal_o | output | 1 | Register layout is illegal |
| reason_o | output | 3 | First failing rule, coded as in R2 |

## Verification
The assertions check the following on every cycle: the flag agrees with the code, and a widening op with an odd vd and a non-negative exponent reports misalignment one cycle later. They also check that a narrowing op with a negative exponent and a scalar first source is always legal, and that a widening op with vd 0, a double-width vs2 and a scalar first source is legal. The exact edges of the widening and narrowing windows, the priority when rules collide, the vs1 gating and the behaviour at the top register numbers can only be shown by the bench's directed vectors.

// File: rtl/vrg_pkg.sv
package vrg_pkg;
    localparam int REG_W  = 5;
    localparam int LMUL_W = 3;
    localparam int NUM_SRC = 2;

    typedef enum logic [2:0] {
        RSN_OK        = 3'd0,
        RSN_DST_ALIGN = 3'd1,
        RSN_SRC_ALIGN = 3'd2,
        RSN_VS2_OVL   = 3'd3,
        RSN_VS1_OVL   = 3'd4
    } reason_e;

    typedef struct packed {
        logic    illegal;
        reason_e reason;
    } verdict_t;
endpackage

// File: rtl/vrg_group.sv
module vrg_group #(
    parameter int LMUL_W = 3,
    parameter int REG_W  = 5,
    parameter int SUM_W  = REG_W + 2
) (
    input  logic signed [LMUL_W-1:0] lmul_i,
    output logic        [SUM_W-1:0]  grp_o,
    output logic        [REG_W-1:0]  mask_o
);
    localparam int EXP_W = LMUL_W + 1;

    logic signed [EXP_W-1:0] exp1;
    logic        [SUM_W-1:0] grp_m1;

    always_comb begin
        exp1 = EXP_W'(lmul_i) + EXP_W'(1);
        if (exp1 > 0) begin
            grp_o = SUM_W'(1) << unsigned'(exp1);
        end else begin
            grp_o = SUM_W'(1);
        end
        grp_m1 = grp_o - SUM_W'(1);
        mask_o = grp_m1[REG_W-1:0];
    end
endmodule

// File: rtl/vrg_align.sv
module vrg_align #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] reg_i,
    input  logic [REG_W-1:0] mask_i,
    output logic             misaligned_o
);
    always_comb begin
        misaligned_o = |(reg_i & mask_i);
    end
endmodule

// File: rtl/vrg_window.sv
module vrg_window #(
    parameter int LMUL_W = 3,
    parameter int REG_W  = 5,
    parameter int SUM_W  = REG_W + 2
) (
    input  logic [REG_W-1:0]         src_i,
    input  logic [REG_W-1:0]         vd_i,
    input  logic [SUM_W-1:0]         grp_i,
    input  logic signed [LMUL_W:0]   emul_i,
    input  logic                     narrow_i,
    input  logic                     en_i,
    output logic                     hit_o
);
    logic [SUM_W-1:0] src_w;
    logic [SUM_W-1:0] vd_w;
    logic [SUM_W-1:0] pow_w;
    logic             wide_hit;
    logic             narrow_hit;

    always_comb begin
        src_w = {{(SUM_W-REG_W){1'b0}}, src_i};
        vd_w  = {{(SUM_W-REG_W){1'b0}}, vd_i};
        if (emul_i < 0) begin
            pow_w = SUM_W'(1);
        end else begin
            pow_w = SUM_W'(1) << unsigned'(emul_i);
        end

        if (emul_i < 0) begin
            wide_hit = (src_w == vd_w);
        end else begin
            wide_hit = (src_w < (vd_w + grp_i - pow_w)) &&
                       (vd_w < (src_w + pow_w));
        end

        narrow_hit = (src_w < vd_w) &&
                     (vd_w <= (src_w + grp_i - SUM_W'(1)));

        hit_o = en_i && (narrow_i ? narrow_hit : wide_hit);
    end
endmodule

// File: rtl/vrg_overlap_checker.sv
module vrg_overlap_checker
    import vrg_pkg::*;
#(
    parameter int P_REG_W  = REG_W,
    parameter int P_LMUL_W = LMUL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [P_REG_W-1:0]  vd_i,
    input  logic [P_REG_W-1:0]  vs1_i,
    input  logic [P_REG_W-1:0]  vs2_i,
    input  logic [P_LMUL_W-1:0] lmul_exp_i,
    input  logic                is_narrow_i,
    input  logic                vs2_wide_i,
    input  logic                vs1_vec_i,
    output logic                illegal_o,
    output logic [2:0]          reason_o
);
    localparam int SUM_W = P_REG_W + 2;
    localparam int EXP_W = P_LMUL_W + 1;

    logic signed [P_LMUL_W-1:0] lmul_s;
    logic [SUM_W-1:0]           grp;
    logic [P_REG_W-1:0]         mask;
    logic [P_REG_W-1:0]         align_reg;
    logic                       misaligned;

    logic [P_REG_W-1:0]         src_reg [NUM_SRC];
    logic signed [EXP_W-1:0]    src_emul [NUM_SRC];
    logic                       src_en [NUM_SRC];
    logic                       src_hit [NUM_SRC];

    verdict_t verdict_d;
    verdict_t verdict_q;

    assign lmul_s = signed'(lmul_exp_i);

    vrg_group #(.LMUL_W(P_LMUL_W), .REG_W(P_REG_W), .SUM_W(SUM_W)) u_group (
        .lmul_i (lmul_s),
        .grp_o  (grp),
        .mask_o (mask)
    );

    // widening aligns the destination, narrowing aligns the wide source
    assign align_reg = is_narrow_i ? vs2_i : vd_i;

    vrg_align #(.REG_W(P_REG_W)) u_align (
        .reg_i        (align_reg),
        .mask_i       (mask),
        .misaligned_o (misaligned)
    );

    // source 0 is vs2, source 1 is vs1
    always_comb begin
        src_reg[0]  = vs2_i;
        src_emul[0] = EXP_W'(lmul_s) + (vs2_wide_i ? EXP_W'(1) : EXP_W'(0));
        src_en[0]   = is_narrow_i || !vs2_wide_i;
        src_reg[1]  = vs1_i;
        src_emul[1] = EXP_W'(lmul_s);
        src_en[1]   = vs1_vec_i;
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        vrg_window #(.LMUL_W(P_LMUL_W), .REG_W(P_REG_W), .SUM_W(SUM_W)) u_win (
            .src_i    (src_reg[s]),
            .vd_i     (vd_i),
            .grp_i    (grp),
            .emul_i   (src_emul[s]),
            .narrow_i (is_narrow_i),
            .en_i     (src_en[s]),
            .hit_o    (src_hit[s])
        );
    end

    always_comb begin
        verdict_d.illegal = misaligned || src_hit[0] || src_hit[1];
        if (misaligned) begin
            verdict_d.reason = is_narrow_i ? RSN_SRC_ALIGN : RSN_DST_ALIGN;
        end else if (src_hit[0]) begin
            verdict_d.reason = RSN_VS2_OVL;
        end else if (src_hit[1]) begin
            verdict_d.reason = RSN_VS1_OVL;
        end else begin
            verdict_d.reason = RSN_OK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_q <= '{illegal: 1'b0, reason: RSN_OK};
        end else begin
            verdict_q <= verdict_d;
        end
    end

    assign illegal_o = verdict_q.illegal;
    assign reason_o  = verdict_q.reason;
endmodule

// File: rtl/vrg_overlap_checker_sva.sv
module vrg_overlap_checker_sva (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] vd_i,
    input logic [2:0] lmul_exp_i,
    input logic       is_narrow_i,
    input logic       vs2_wide_i,
    input logic       vs1_vec_i,
    input logic       illegal_o,
    input logic [2:0] reason_o
);
    // R2: flag and code agree
    assert_flag_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o == (reason_o != 3'd0));

    // R3: odd vd on a widening op with G >= 2 is a destination misalignment
    assert_dst_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_narrow_i && !lmul_exp_i[2] && vd_i[0]) |=> (reason_o == 3'd1));

    // R9: narrowing with G = 1 and a scalar first source is always legal
    assert_narrow_unit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_narrow_i && lmul_exp_i[2] && !vs1_vec_i) |=> !illegal_o);

    // R7: a double-width vs2 never causes a widening violation
    assert_wide_vs2_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_narrow_i && vs2_wide_i && !vs1_vec_i && vd_i == 5'd0) |=> !illegal_o);
endmodule

bind vrg_overlap_checker vrg_overlap_checker_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .vd_i        (vd_i),
    .lmul_exp_i  (lmul_exp_i),
    .is_narrow_i (is_narrow_i),
    .vs2_wide_i  (vs2_wide_i),
    .vs1_vec_i   (vs1_vec_i),
    .illegal_o   (illegal_o),
    .reason_o    (reason_o)
);

// File: tb/sim_vrg_overlap_checker.sv
module sim_vrg_overlap_checker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] vd_i = '0, vs1_i = '0, vs2_i = '0;
    logic [2:0] lmul_exp_i = '0;
    logic       is_narrow_i = 1'b0, vs2_wide_i = 1'b0, vs1_vec_i = 1'b0;
    logic       illegal_o;
    logic [2:0] reason_o;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    vrg_overlap_checker u0 (
        .clk(clk), .rst_n(rst_n), .vd_i(vd_i), .vs1_i(vs1_i), .vs2_i(vs2_i),
        .lmul_exp_i(lmul_exp_i), .is_narrow_i(is_narrow_i),
        .vs2_wide_i(vs2_wide_i), .vs1_vec_i(vs1_vec_i),
        .illegal_o(illegal_o), .reason_o(reason_o)
    );

    task automatic check(input string req, input logic [2:0] exp_r);
        n_checks++;
        if (reason_o !== exp_r || illegal_o !== (exp_r != 3'd0)) begin
            n_fail++;
            $display("FAIL %s: reason=%0d illegal=%0b expected reason=%0d illegal=%0b",
                     req, reason_o, illegal_o, exp_r, exp_r != 3'd0);
        end
    endtask

    // drive at negedge, verdict registered at next posedge, sample 1 ns later
    task automatic apply(input string req, input logic narrow, input logic [2:0] lmul,
                         input logic [4:0] vd, input logic [4:0] vs2, input logic [4:0] vs1,
                         input logic wide, input logic vec, input logic [2:0] exp_r);
        @(negedge clk);
        is_narrow_i = narrow; lmul_exp_i = lmul; vd_i = vd; vs2_i = vs2;
        vs1_i = vs1; vs2_wide_i = wide; vs1_vec_i = vec;
        @(posedge clk);
        #1;
        check(req, exp_r);
    endtask

    task automatic t_reset;
        @(negedge clk);
        is_narrow_i = 1'b0; lmul_exp_i = 3'd0; vd_i = 5'd3; vs2_i = 5'd3;
        @(posedge clk);
        #1;
        check("R1 reset", 3'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 latency", 3'd1);
    endtask

    task automatic t_align;
        apply("R3 vd=3 G=2", 1'b0, 3'd0, 5'd3, 5'd8, 5'd0, 1'b0, 1'b0, 3'd1);
        apply("R3 vd=6 G=4", 1'b0, 3'd1, 5'd6, 5'd16, 5'd0, 1'b0, 1'b0, 3'd1);
        apply("R3 vd=7 G=1", 1'b0, 3'b111, 5'd7, 5'd20, 5'd0, 1'b0, 1'b0, 3'd0);
        apply("R4 vs2=5 G=2", 1'b1, 3'd0, 5'd20, 5'd5, 5'd0, 1'b0, 1'b0, 3'd2);
        apply("R4 odd vd ok", 1'b1, 3'd0, 5'd3, 5'd4, 5'd0, 1'b0, 1'b0, 3'd0);
    endtask

    task automatic t_widen;
        apply("R5 equal", 1'b0, 3'b110, 5'd5, 5'd5, 5'd0, 1'b0, 1'b0, 3'd3);
        apply("R5 adjacent", 1'b0, 3'b110, 5'd5, 5'd6, 5'd0, 1'b0, 1'b0, 3'd0);
        apply("R6 top half", 1'b0, 3'd1, 5'd8, 5'd10, 5'd0, 1'b0, 1'b0, 3'd0);
        apply("R6 straddle", 1'b0, 3'd1, 5'd8, 5'd9, 5'd0, 1'b0, 1'b0, 3'd3);
        apply("R6 base", 1'b0, 3'd1, 5'd8, 5'd8, 5'd0, 1'b0, 1'b0, 3'd3);
        apply("R6 below hit", 1'b0, 3'd1, 5'd8, 5'd7, 5'd0, 1'b0, 1'b0, 3'd3);
        apply("R6 below clear", 1'b0, 3'd1, 5'd8, 5'd6, 5'd0, 1'b0, 1'b0, 3'd0);
        apply("R7 wide vs2", 1'b0, 3'd1, 5'd8, 5'd8, 5'd0, 1'b1, 1'b0, 3'd0);
    endtask

    task automatic t_vs1;
        apply("R8 widen vs1 vec", 1'b0, 3'd1, 5'd8, 5'd16, 5'd9, 1'b0, 1'b1, 3'd4);
        apply("R8 widen vs1 scalar", 1'b0, 3'd1, 5'd8, 5'd16, 5'd9, 1'b0, 1'b0, 3'd0);
        apply("R8 narrow vs1 vec", 1'b1, 3'd0, 5'd5, 5'd6, 5'd4, 1'b0, 1'b1, 3'd4);
        apply("R8 narrow vs1 scalar", 1'b1, 3'd0, 5'd5, 5'd6, 5'd4, 1'b0, 1'b0, 3'd0);
    endtask

    task automatic t_narrow;
        apply("R9 vd at base", 1'b1, 3'd1, 5'd8, 5'd8, 5'd0, 1'b0, 1'b0, 3'd0);
        apply("R9 vd top", 1'b1, 3'd1, 5'd11, 5'd8, 5'd0, 1'b0, 1'b0, 3'd3);
        apply("R9 vd inside", 1'b1, 3'd1, 5'd9, 5'd8, 5'd0, 1'b0, 1'b0, 3'd3);
        apply("R9 vd past", 1'b1, 3'd1, 5'd12, 5'd8, 5'd0, 1'b0, 1'b0, 3'd0);
        apply("R9 vs2 wide flag", 1'b1, 3'd1, 5'd9, 5'd8, 5'd0, 1'b1, 1'b0, 3'd3);
    endtask

    task automatic t_priority;
        apply("R10 align first", 1'b0, 3'd0, 5'd3, 5'd3, 5'd3, 1'b0, 1'b1, 3'd1);
        apply("R10 vs2 before vs1", 1'b0, 3'd0, 5'd4, 5'd4, 5'd4, 1'b0, 1'b1, 3'd3);
        apply("R10 narrow align first", 1'b1, 3'd0, 5'd4, 5'd3, 5'd3, 1'b0, 1'b1, 3'd2);
    endtask

    task automatic t_range;
        apply("R11 G=16 clear", 1'b0, 3'd3, 5'd16, 5'd31, 5'd0, 1'b0, 1'b0, 3'd0);
        apply("R11 G=16 hit", 1'b0, 3'd3, 5'd16, 5'd23, 5'd0, 1'b0, 1'b0, 3'd3);
        apply("R11 G=16 low", 1'b0, 3'd3, 5'd16, 5'd4, 5'd0, 1'b0, 1'b0, 3'd0);
        apply("R11 narrow top", 1'b1, 3'd3, 5'd31, 5'd16, 5'd0, 1'b0, 1'b0, 3'd3);
        apply("R11 lmul -3", 1'b0, 3'b101, 5'd9, 5'd9, 5'd0, 1'b0, 1'b0, 3'd3);
    endtask

    initial begin
        t_reset();
        t_align();
        t_widen();
        t_vs1();
        t_narrow();
        t_priority();
        t_range();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule